// File: doc/BRIEF.md
# Serial Configuration Image Loader

This block loads configuration images into reconfigurable targets so the host does not have to send an image every time. Several pre-built images are held in a local ROM. The host issues a request carrying three things: a base word address, a length in words and a target index. The block's state machine then reads the words in that range from the ROM through a synchronous read port and sends them out as a serial stream. Each word goes out most significant bit first. The serial interface has three signals: a configuration clock that runs at half the system clock, an enable that qualifies that clock, and a data bit.

A request covers any sub-range of the ROM, so it can deliver a whole image or only a partial update. There are two delivery models.

- **Chained:** every target shares the clock and the enable. The stream enters at target 0, and each target's serial output feeds the next target.
- **Select:** the stream, clock and enable are steered to the one addressed target, and every other target stays quiet.

The host watches a busy flag and a one-cycle completion pulse.

Top module: `cfg_loader`

## Requirements
- R1: While reset is applied, and until the first request, busy, done, rom_rd_en and all target clock, enable and data outputs are 0.
- R2: A req_start seen while the block is idle with req_len non-zero is accepted, and busy reads 1 one cycle later. A request with req_len equal to 0 is ignored and busy stays 0.
- R3: For an accepted request the ROM words at req_base, req_base+1, ..., req_base+req_len-1 are delivered in ascending order. Bit DW-1 of each word goes first, and exactly one bit is delivered per rising edge of the configuration clock.
- R4: The configuration clock is high for exactly one system cycle and then low for at least one. The data bit never changes in a cycle in which the clock is high, so a target samples it on the rising edge.
- R5: With req_chain=1 (chained), every target receives the clock and the enable. The stream appears only on tgt_data[0], tgt_data of every other target stays 0, and req_target has no effect.
- R6: With req_chain=0 (select), only target req_target receives the clock, enable and data. All other targets see 0 on all three.
- R7: busy stays 1 until the last bit's clock pulse has ended. done is 1 for exactly one cycle, which is the first cycle in which busy reads 0.
- R8: req_start is ignored while busy is 1 or done is 1. Such a request neither alters the stream in progress nor starts a new load.
- R9: While busy is 0, every target clock, enable and data output is 0.
- R10: The enable of each receiving target stays 1 without a break from the first bit of a request to its last, including the gaps between words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Request strobe |
| req_chain | input | 1 | 1 = chained delivery, 0 = select delivery |
| req_base | input | AW | First ROM word of the request |
| req_len | input | LW | Number of words to send |
| req_target | input | TW | Target addressed in select delivery |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |
| rom_rd_en | output | 1 | ROM read strobe |
| rom_addr | output | AW | ROM word address |
| rom_rd_data | input | DW | ROM data, valid one cycle after the strobe |
| tgt_clk | output | NT | Configuration clock per target |
| tgt_en | output | NT | Configuration enable per target |
| tgt_data | output | NT | Serial configuration data per target |

## Verification
The bench drives requests just after a falling system clock edge and samples every output on falling edges.

- **Busy:** busy is checked on the very next falling edge after a request, because it is due one register stage after acceptance.
- **Done:** done is checked in the first sample where busy reads 0, and the following sample must show it gone.
- **Serial bits:** a bit is captured at each sample in which a target's clock has just risen with its enable high. Since the data must hold through that high cycle, the captured bit is the one the target would latch. Each captured stream is compared, bit by bit and by count, with the stream the bench computes from its own ROM function after done.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [2:0] {
    LD_IDLE  = 3'd0,
    LD_READ  = 3'd1,
    LD_LOAD  = 3'd2,
    LD_SHIFT = 3'd3,
    LD_FIN   = 3'd4
  } ld_state_t;

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = chain_q[STAGES-1];

endmodule

// File: rtl/cfg_word_fetch.sv
module cfg_word_fetch #(
  parameter int AW = 8,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] len,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          none_left
);

  logic [AW-1:0] addr_q, addr_d;
  logic [LW-1:0] left_q, left_d;
  logic          upd;

  always_comb begin
    upd    = load | step;
    addr_d = addr_q;
    left_d = left_q;
    if (load) begin
      addr_d = base;
      left_d = len;
    end else if (step) begin
      addr_d = addr_q + AW'(1);
      left_d = left_q - LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= '0;
    end else if (upd) begin
      addr_q <= addr_d;
      left_q <= left_d;
    end
  end

  assign addr      = addr_q;
  assign none_left = (left_q == '0);

  AST_STEP_HAS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |-> (left_q != '0)); // R3

endmodule

// File: rtl/cfg_serializer.sv
module cfg_serializer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] word_in,
  input  logic          run,
  output logic          ser_clk,
  output logic          ser_bit,
  output logic          word_end
);

  localparam int BCW = (DW > 1) ? $clog2(DW) : 1;

  logic [DW-1:0]  sh_q, sh_d;
  logic [BCW-1:0] cnt_q, cnt_d;
  logic           ph_q, ph_d;
  logic           upd;

  always_comb begin
    upd  = load | run;
    sh_d = sh_q;
    cnt_d = cnt_q;
    ph_d = ph_q;
    if (load) begin
      sh_d  = word_in;
      cnt_d = '0;
      ph_d  = 1'b0;
    end else if (run) begin
      ph_d = ~ph_q;
      if (ph_q) begin
        sh_d  = {sh_q[DW-2:0], 1'b0};
        cnt_d = cnt_q + BCW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (upd) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign ser_clk  = run & ph_q;
  assign ser_bit  = sh_q[DW-1];
  assign word_end = run & ph_q & (cnt_q == BCW'(DW-1));

  AST_BIT_STABLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> $stable(ser_bit)); // R4
  AST_CLK_ONE_CYCLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |=> !ser_clk); // R4

endmodule

// File: rtl/cfg_target_route.sv
module cfg_target_route #(
  parameter int NT = 4,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chain,
  input  logic [TW-1:0] sel,
  input  logic          s_clk,
  input  logic          s_en,
  input  logic          s_data,
  output logic [NT-1:0] t_clk,
  output logic [NT-1:0] t_en,
  output logic [NT-1:0] t_data
);

  for (genvar i = 0; i < NT; i++) begin : g_tgt
    logic hit;
    if (i == 0) begin : g_head
      assign hit       = chain | (sel == TW'(i));
      assign t_data[i] = hit & s_data;
    end else begin : g_rest
      assign hit       = chain | (sel == TW'(i));
      assign t_data[i] = ~chain & (sel == TW'(i)) & s_data;
    end
    assign t_clk[i] = hit & s_clk;
    assign t_en[i]  = hit & s_en;
  end

  AST_SELECT_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !chain |-> $onehot0(t_en)); // R6
  AST_CHAIN_ALL_TARGETS: assert property (@(posedge clk) disable iff (!rst_n)
    (chain && s_en) |-> (t_en == {NT{1'b1}})); // R5

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter int LW = 8,
  parameter int NT = 4,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_start,
  input  logic          req_chain,
  input  logic [AW-1:0] req_base,
  input  logic [LW-1:0] req_len,
  input  logic [TW-1:0] req_target,
  output logic          busy,
  output logic          done,
  output logic          rom_rd_en,
  output logic [AW-1:0] rom_addr,
  input  logic [DW-1:0] rom_rd_data,
  output logic [NT-1:0] tgt_clk,
  output logic [NT-1:0] tgt_en,
  output logic [NT-1:0] tgt_data
);

  logic          rst_q_n;
  ld_state_t     st_q, st_d;
  logic          accept;
  logic          chain_q;
  logic [TW-1:0] tgt_q;
  logic          none_left;
  logic          ser_clk, ser_bit, word_end;
  logic          s_en, s_data;

  cfg_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  assign accept = (st_q == LD_IDLE) & req_start & (req_len != '0);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LD_IDLE:  if (accept) st_d = LD_READ;
      LD_READ:  st_d = LD_LOAD;
      LD_LOAD:  st_d = LD_SHIFT;
      LD_SHIFT: if (word_end) st_d = none_left ? LD_FIN : LD_READ;
      LD_FIN:   st_d = LD_IDLE;
      default:  st_d = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) st_q <= LD_IDLE;
    else          st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      chain_q <= 1'b0;
      tgt_q   <= '0;
    end else if (accept) begin
      chain_q <= req_chain;
      tgt_q   <= req_target;
    end
  end

  cfg_word_fetch #(.AW(AW), .LW(LW)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .load      (accept),
    .base      (req_base),
    .len       (req_len),
    .step      (st_q == LD_READ),
    .addr      (rom_addr),
    .none_left (none_left)
  );

  cfg_serializer #(.DW(DW)) u_ser (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .load     (st_q == LD_LOAD),
    .word_in  (rom_rd_data),
    .run      (st_q == LD_SHIFT),
    .ser_clk  (ser_clk),
    .ser_bit  (ser_bit),
    .word_end (word_end)
  );

  assign busy      = (st_q == LD_READ) | (st_q == LD_LOAD) | (st_q == LD_SHIFT);
  assign done      = (st_q == LD_FIN);
  assign rom_rd_en = (st_q == LD_READ);
  assign s_en      = busy;
  assign s_data    = busy & ser_bit;

  cfg_target_route #(.NT(NT)) u_route (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .chain  (chain_q),
    .sel    (tgt_q),
    .s_clk  (ser_clk),
    .s_en   (s_en),
    .s_data (s_data),
    .t_clk  (tgt_clk),
    .t_en   (tgt_en),
    .t_data (tgt_data)
  );

  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!busy && !done && req_start && req_len != '0) |=> busy); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    done |=> !done); // R7
  AST_BUSY_FALL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_q_n)
    $fell(busy) |-> done); // R7
  AST_IDLE_TARGETS_QUIET: assert property (@(posedge clk) disable iff (!rst_q_n)
    !busy |-> (tgt_en == '0 && tgt_clk == '0 && tgt_data == '0)); // R9
  AST_EN_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_q_n)
    busy |-> (tgt_en != '0)); // R10
  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_q_n)
    (busy && !word_end) |=> busy); // R8

endmodule

// File: tb/tb_cfg_loader.sv
module tb_cfg_loader;

  localparam int DW = 8;
  localparam int AW = 8;
  localparam int LW = 8;
  localparam int NT = 4;
  localparam int TW = 2;
  localparam int BUFN = 512;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_start = 1'b0;
  logic          req_chain = 1'b0;
  logic [AW-1:0] req_base = '0;
  logic [LW-1:0] req_len = '0;
  logic [TW-1:0] req_target = '0;
  logic          busy, done, rom_rd_en;
  logic [AW-1:0] rom_addr;
  logic [DW-1:0] rom_q;
  logic [NT-1:0] tgt_clk, tgt_en, tgt_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit ended  = 1'b0;

  always #10 clk = ~clk;

  cfg_loader #(.DW(DW), .AW(AW), .LW(LW), .NT(NT)) dut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_chain(req_chain),
    .req_base(req_base), .req_len(req_len), .req_target(req_target),
    .busy(busy), .done(done), .rom_rd_en(rom_rd_en), .rom_addr(rom_addr),
    .rom_rd_data(rom_q), .tgt_clk(tgt_clk), .tgt_en(tgt_en), .tgt_data(tgt_data)
  );

  function automatic logic [DW-1:0] rom_fn(input logic [AW-1:0] a);
    logic [DW-1:0] v;
    v = DW'(a) * 8'd29 + 8'd71;
    return v ^ DW'(a >> 3);
  endfunction

  always @(posedge clk) if (rom_rd_en) rom_q <= rom_fn(rom_addr);

  // Target-side observers: record a bit on each rising configuration clock
  logic [NT-1:0] prev_clk = '0;
  logic          bitbuf [NT][BUFN];
  int            bcnt [NT];
  int            en_breaks = 0;
  int            side_data = 0;
  logic [NT-1:0] prev_en = '0;

  initial for (int i = 0; i < NT; i++) bcnt[i] = 0;

  always @(negedge clk) begin
    for (int i = 0; i < NT; i++) begin
      if (tgt_clk[i] && !prev_clk[i] && tgt_en[i]) begin
        bitbuf[i][bcnt[i] % BUFN] = tgt_data[i];
        bcnt[i] = bcnt[i] + 1;
      end
      if (busy && prev_en[i] && !tgt_en[i]) en_breaks = en_breaks + 1;
      if (i > 0 && req_chain_act && tgt_data[i]) side_data = side_data + 1;
    end
    prev_clk = tgt_clk;
    prev_en  = tgt_en;
  end

  logic req_chain_act = 1'b0;

  task automatic report();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !ended) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      report();
    end
  end

  task automatic run_req(input int base, input int len, input int tgt, input bit chain,
                         input bit inject);
    int snap [NT];
    int brk0, side0, n, idx;
    bit mism;
    for (int i = 0; i < NT; i++) snap[i] = bcnt[i];
    brk0  = en_breaks;
    side0 = side_data;
    @(negedge clk);
    req_chain_act = chain;
    req_start  = 1'b1;
    req_chain  = chain;
    req_base   = AW'(base);
    req_len    = LW'(len);
    req_target = TW'(tgt);
    @(negedge clk);
    req_start = 1'b0;
    chk(busy == 1'b1, "R2 busy after accept", busy, 1);
    if (inject) begin
      repeat (5) @(negedge clk);
      req_start  = 1'b1;
      req_chain  = ~chain;
      req_base   = AW'(base + 7);
      req_len    = LW'(3);
      req_target = TW'(tgt + 1);
      @(negedge clk);
      req_start = 1'b0;
    end
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R7 done seen", done, 1);
    chk(busy == 1'b0, "R7 busy low with done", busy, 0);
    if (inject) begin
      req_start = 1'b1;
      req_len   = LW'(2);
    end
    @(negedge clk);
    req_start = 1'b0;
    chk(done == 1'b0, "R7 done one cycle", done, 0);
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R8 no load from ignored request", busy, 0);
    chk(tgt_en == '0 && tgt_clk == '0 && tgt_data == '0, "R9 idle targets quiet",
        {tgt_en, tgt_clk, tgt_data}, 0);
    for (int i = 0; i < NT; i++) begin
      int expn;
      expn = (chain || i == tgt) ? len * DW : 0;
      chk(bcnt[i] - snap[i] == expn, chain ? "R5 chain bit count" : "R6 select bit count",
          bcnt[i] - snap[i], expn);
    end
    idx  = chain ? 0 : tgt;
    mism = 1'b0;
    for (int w = 0; w < len; w++)
      for (int b = 0; b < DW; b++) begin
        logic [DW-1:0] wv;
        wv = rom_fn(AW'(base + w));
        if (bitbuf[idx][(snap[idx] + w * DW + b) % BUFN] !== wv[DW-1-b]) mism = 1'b1;
      end
    chk(!mism, "R3 stream matches ROM range MSB first", mism, 0);
    chk(en_breaks == brk0, "R10 enable unbroken", en_breaks - brk0, 0);
    if (chain) chk(side_data == side0, "R5 non-head data low", side_data - side0, 0);
    req_chain_act = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && rom_rd_en == 0, "R1 reset control outputs",
        {busy, done, rom_rd_en}, 0);
    chk(tgt_clk == 0 && tgt_en == 0 && tgt_data == 0, "R1 reset target outputs",
        {tgt_clk, tgt_en, tgt_data}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(busy == 0 && tgt_en == 0, "R1 idle after reset", {busy, tgt_en}, 0);

    // zero-length request is ignored
    @(negedge clk);
    req_start = 1'b1; req_len = '0; req_base = 8'd10;
    @(negedge clk);
    req_start = 1'b0;
    chk(busy == 1'b0, "R2 zero length ignored", busy, 0);
    repeat (4) @(negedge clk);
    chk(tgt_clk == '0 && busy == 1'b0, "R2 zero length no clocks", {busy, tgt_clk}, 0);

    // directed corners
    run_req(0, 1, 2, 1'b0, 1'b0);      // single word, select
    run_req(255, 1, 0, 1'b1, 1'b0);    // last ROM word, chain
    run_req(40, 6, 3, 1'b1, 1'b0);     // chain, target index must not matter (R5)
    run_req(100, 5, 1, 1'b0, 1'b1);    // request while busy ignored (R8)
    run_req(12, 12, 0, 1'b0, 1'b0);

    // random mix
    for (int k = 0; k < 24; k++) begin
      int b, l, t;
      bit c, inj;
      b   = int'($urandom_range(0, 200));
      l   = int'($urandom_range(1, 12));
      t   = int'($urandom_range(0, NT - 1));
      c   = 1'($urandom_range(0, 1));
      inj = ($urandom_range(0, 3) == 0);
      run_req(b, l, t, c, inj);
    end
    report();
  end

endmodule